// File: doc/BRIEF.md
# Memory-Resident Mailbox Ring Controller

The block looks after a set of mailboxes, each one a ring of fixed-size indication words kept in system memory. For every mailbox the host programs four address registers: the first entry of the ring, the bound that lies one step past the last entry, the producer position and the consumer position. When the cell engine posts an indication for a mailbox, the block issues one memory write at that mailbox's producer position and moves the position on by one indication. On reaching the bound, the position goes back to the first entry.

The host drains a ring and then stores the address of the next unread indication into the consumer register. If a post leaves the producer position equal to the consumer position, the ring counts as full. A sticky full flag is then set, and a halt output stops all command execution until the host frees space and clears the flag. Every post also sets a sticky "indication present" flag. Each flag has its own interrupt enable, and the enabled flags are ORed into one registered interrupt line.

Top module: `mbox_ring_ctrl`

## Requirements
- R1: Register address `{mailbox, field}` selects, for mailbox index m (address 4*m+f), field f = 0 first entry, 1 bound, 2 producer position, 3 consumer position. Address 4*NUM_MBOX is the status register and 4*NUM_MBOX+1 is the interrupt-enable register. Other addresses read 0. `reg_rdata` shows the register addressed in a cycle on the following cycle, with its value from before any write in that cycle.
- R2: A post is accepted in a cycle where `ind_valid` and `ind_ready` are both high. In that same cycle `mem_wr_en` is high, `mem_addr` equals the addressed mailbox's producer position and `mem_wdata` equals `ind_data`. `mem_wr_en` is low in every other cycle.
- R3: After an accepted post the producer position becomes its old value plus IND_BYTES. If that sum equals the bound, the producer position becomes the first-entry address instead.
- R4: An accepted post to mailbox m sets status bit m (indication present).
- R5: If the new producer position after a post equals that mailbox's consumer position, status bit NUM_MBOX+m (full) is set.
- R6: `halt` is high in the cycle after any full bit is set, and low in the cycle after all full bits are clear.
- R7: `ind_ready` equals `mem_ready` AND NOT the full bit of the mailbox selected by `ind_mbox`.
- R8: `irq` equals the OR of (status AND interrupt-enable) as it stood one cycle earlier. Interrupt-enable bit positions match the status bit positions.
- R9: Writing the status register clears each bit written as 1. A bit being set in the same cycle stays set. A write that would clear full bit NUM_MBOX+m is ignored while mailbox m's consumer position equals its producer position.
- R10: While `rst` is high, all pointer registers, status and interrupt-enable bits are cleared, and `irq` and `halt` are low.
- R11: A host write to a mailbox's producer position in the same cycle as an accepted post to that mailbox takes priority over the post's advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Host register write strobe |
| reg_addr | input | RA_W | Host register address (read and write) |
| reg_wdata | input | AW | Host write data |
| reg_rdata | output | AW | Registered read data |
| ind_valid | input | 1 | Cell engine offers an indication |
| ind_mbox | input | MB_W | Target mailbox of the indication |
| ind_data | input | DW | Indication word |
| ind_ready | output | 1 | Indication can be accepted |
| mem_ready | input | 1 | Memory port can take a write |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | DW | Memory write data |
| irq | output | 1 | Registered interrupt |
| halt | output | 1 | Command execution stop |

## Verification
The bench uses four mailboxes, 16-bit addresses, a 32-bit indication word and the default 16-byte step. With these values a ring of four entries wraps after four posts, so the wrap, the full condition and the re-fill after one consumed slot can each be reached in a few dozen cycles. With four mailboxes, a full ring can be blocked while a post to another ring is still accepted, and the packed status and enable registers carry full bits above bit 3, which tests the bit positions.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [1:0] {
    FLD_START  = 2'd0,
    FLD_BOUND  = 2'd1,
    FLD_WPTR   = 2'd2,
    FLD_TAIL   = 2'd3
  } mbox_field_e;
endpackage

// File: rtl/mbox_ring_ptr.sv
module mbox_ring_ptr
  import mbox_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned STEP = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_we,
  input  mbox_field_e   host_fld,
  input  logic [AW-1:0] host_wdata,
  input  logic          post_fire,
  output logic [AW-1:0] start_o,
  output logic [AW-1:0] bound_o,
  output logic [AW-1:0] wptr_o,
  output logic [AW-1:0] tail_o,
  output logic          hit_tail_o,
  output logic          release_ok_o
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  logic [AW-1:0] adv;
  logic [AW-1:0] nxt;
  logic          host_wptr;

  assign adv          = wptr_o + STEP_V;
  assign nxt          = (adv == bound_o) ? start_o : adv;
  assign hit_tail_o   = post_fire && (nxt == tail_o);
  assign release_ok_o = (tail_o != wptr_o);
  assign host_wptr    = host_we && (host_fld == FLD_WPTR);

  always_ff @(posedge clk) begin
    if (rst) begin
      start_o <= '0;
      bound_o <= '0;
      wptr_o  <= '0;
      tail_o  <= '0;
    end else begin
      if (host_we && host_fld == FLD_START) start_o <= host_wdata;
      if (host_we && host_fld == FLD_BOUND) bound_o <= host_wdata;
      if (host_we && host_fld == FLD_TAIL)  tail_o  <= host_wdata;
      if (host_wptr)      wptr_o <= host_wdata;
      else if (post_fire) wptr_o <= nxt;
    end
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (post_fire && !host_wptr) |=>
      ((wptr_o == $past(wptr_o) + STEP_V) || (wptr_o == $past(start_o)))); // R3
  AST_HOST_WPTR_WINS: assert property (@(posedge clk) disable iff (rst)
    host_wptr |=> (wptr_o == $past(host_wdata))); // R11
endmodule

// File: rtl/mbox_status.sv
module mbox_status #(
  parameter int unsigned NUM_MBOX = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_MBOX-1:0]   present_set,
  input  logic [NUM_MBOX-1:0]   full_set,
  input  logic [NUM_MBOX-1:0]   release_ok,
  input  logic                  clr_we,
  input  logic                  mask_we,
  input  logic [2*NUM_MBOX-1:0] wdata,
  output logic [2*NUM_MBOX-1:0] status_o,
  output logic [2*NUM_MBOX-1:0] mask_o,
  output logic                  irq,
  output logic                  halt
);
  localparam int unsigned SW = 2 * NUM_MBOX;

  logic [SW-1:0] clr_eff;
  logic [SW-1:0] set_v;

  always_comb begin
    clr_eff = clr_we ? wdata : '0;
    clr_eff[SW-1:NUM_MBOX] = clr_eff[SW-1:NUM_MBOX] & release_ok;
    set_v = {full_set, present_set};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o <= '0;
      mask_o   <= '0;
      irq      <= 1'b0;
      halt     <= 1'b0;
    end else begin
      status_o <= (status_o & ~clr_eff) | set_v;
      if (mask_we) mask_o <= wdata;
      irq  <= |(status_o & mask_o);
      halt <= |status_o[SW-1:NUM_MBOX];
    end
  end

  for (genvar i = 0; i < NUM_MBOX; i++) begin : g_chk
    AST_FULL_STICKY: assert property (@(posedge clk) disable iff (rst)
      $fell(status_o[NUM_MBOX+i]) |->
        $past(clr_we && wdata[NUM_MBOX+i] && release_ok[i])); // R9
  end

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (mask_o == '0) |=> !irq); // R8
  AST_HALT_FOLLOWS_FULL: assert property (@(posedge clk) disable iff (rst)
    halt |-> $past(|status_o[SW-1:NUM_MBOX])); // R6
endmodule

// File: rtl/mbox_ring_ctrl.sv
module mbox_ring_ctrl
  import mbox_pkg::*;
#(
  parameter int unsigned NUM_MBOX  = 4,
  parameter int unsigned AW        = 32,
  parameter int unsigned DW        = 128,
  parameter int unsigned IND_BYTES = 16,
  localparam int unsigned MB_W     = (NUM_MBOX > 1) ? $clog2(NUM_MBOX) : 1,
  localparam int unsigned RA_W     = $clog2(4 * NUM_MBOX + 2)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_wr_en,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [AW-1:0]   reg_wdata,
  output logic [AW-1:0]   reg_rdata,
  input  logic            ind_valid,
  input  logic [MB_W-1:0] ind_mbox,
  input  logic [DW-1:0]   ind_data,
  output logic            ind_ready,
  input  logic            mem_ready,
  output logic            mem_wr_en,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            irq,
  output logic            halt
);
  localparam int unsigned SW        = 2 * NUM_MBOX;
  localparam int unsigned NREG      = 4 * NUM_MBOX;
  localparam int unsigned IW        = RA_W - 2;
  localparam logic [RA_W-1:0] STAT_A = RA_W'(NREG);
  localparam logic [RA_W-1:0] MASK_A = RA_W'(NREG + 1);

  logic [AW-1:0]       start_a [NUM_MBOX];
  logic [AW-1:0]       bound_a [NUM_MBOX];
  logic [AW-1:0]       wptr_a  [NUM_MBOX];
  logic [AW-1:0]       tail_a  [NUM_MBOX];
  logic [NUM_MBOX-1:0] hit_v;
  logic [NUM_MBOX-1:0] rel_v;
  logic [NUM_MBOX-1:0] fire_v;
  logic [SW-1:0]       status_v;
  logic [SW-1:0]       mask_v;
  logic [NUM_MBOX-1:0] full_v;
  logic                fire;
  logic                ptr_sel;
  mbox_field_e         fld;

  assign full_v    = status_v[SW-1:NUM_MBOX];
  assign ind_ready = mem_ready && !full_v[ind_mbox];
  assign fire      = ind_valid && ind_ready;
  assign mem_wr_en = fire;
  assign mem_addr  = wptr_a[ind_mbox];
  assign mem_wdata = ind_data;
  assign ptr_sel   = reg_wr_en && (reg_addr < STAT_A);
  assign fld       = mbox_field_e'(reg_addr[1:0]);

  for (genvar m = 0; m < NUM_MBOX; m++) begin : g_ring
    assign fire_v[m] = fire && (ind_mbox == MB_W'(m));
    mbox_ring_ptr #(.AW(AW), .STEP(IND_BYTES)) u_ptr (
      .clk          (clk),
      .rst          (rst),
      .host_we      (ptr_sel && (reg_addr[RA_W-1:2] == IW'(m))),
      .host_fld     (fld),
      .host_wdata   (reg_wdata),
      .post_fire    (fire_v[m]),
      .start_o      (start_a[m]),
      .bound_o      (bound_a[m]),
      .wptr_o       (wptr_a[m]),
      .tail_o       (tail_a[m]),
      .hit_tail_o   (hit_v[m]),
      .release_ok_o (rel_v[m])
    );
  end

  mbox_status #(.NUM_MBOX(NUM_MBOX)) u_stat (
    .clk         (clk),
    .rst         (rst),
    .present_set (fire_v),
    .full_set    (hit_v),
    .release_ok  (rel_v),
    .clr_we      (reg_wr_en && reg_addr == STAT_A),
    .mask_we     (reg_wr_en && reg_addr == MASK_A),
    .wdata       (reg_wdata[SW-1:0]),
    .status_o    (status_v),
    .mask_o      (mask_v),
    .irq         (irq),
    .halt        (halt)
  );

  logic [AW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (reg_addr == STAT_A)      rd_mux = AW'(status_v);
    else if (reg_addr == MASK_A) rd_mux = AW'(mask_v);
    else begin
      for (int m = 0; m < NUM_MBOX; m++) begin
        if (reg_addr[RA_W-1:2] == IW'(m) && reg_addr < STAT_A) begin
          case (fld)
            FLD_START: rd_mux = start_a[m];
            FLD_BOUND: rd_mux = bound_a[m];
            FLD_WPTR:  rd_mux = wptr_a[m];
            default:   rd_mux = tail_a[m];
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

  AST_NO_POST_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> !full_v[ind_mbox]); // R7
  AST_PRESENT_SET: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |=> status_v[$past(ind_mbox)]); // R4
  AST_FULL_ON_HIT: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_en && hit_v[ind_mbox]) |=> full_v[$past(ind_mbox)]); // R5
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (status_v == '0 && mask_v == '0 && !irq && !halt)); // R10
endmodule

// File: tb/mbox_ring_ctrl_bench.sv
module mbox_ring_ctrl_bench;
  localparam int N = 4;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int STEP = 16;
  localparam int RA_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr_en = 1'b0;
  logic [RA_W-1:0] reg_addr = '0;
  logic [AW-1:0] reg_wdata = '0;
  logic [AW-1:0] reg_rdata;
  logic ind_valid = 1'b0;
  logic [1:0] ind_mbox = '0;
  logic [DW-1:0] ind_data = '0;
  logic ind_ready;
  logic mem_ready = 1'b1;
  logic mem_wr_en;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic irq, halt;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  mbox_ring_ctrl #(.NUM_MBOX(N), .AW(AW), .DW(DW), .IND_BYTES(STEP)) u_mbox_ring_ctrl (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ind_valid(ind_valid),
    .ind_mbox(ind_mbox), .ind_data(ind_data), .ind_ready(ind_ready),
    .mem_ready(mem_ready), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .irq(irq), .halt(halt));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int unsigned m_start[N], m_bound[N], m_wptr[N], m_tail[N];
  bit [7:0] m_stat, m_mask;
  bit m_irq, m_halt;
  int unsigned m_rdata;

  function automatic int unsigned model_read(input int a);
    if (a < 4 * N) begin
      case (a % 4)
        0: return m_start[a / 4];
        1: return m_bound[a / 4];
        2: return m_wptr[a / 4];
        default: return m_tail[a / 4];
      endcase
    end
    if (a == 4 * N) return m_stat;
    if (a == 4 * N + 1) return m_mask;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_start[i]) begin
        m_start[i] = 0; m_bound[i] = 0; m_wptr[i] = 0; m_tail[i] = 0;
      end
      m_stat = 0; m_mask = 0; m_irq = 0; m_halt = 0; m_rdata = 0;
    end else begin
      int mb;
      int unsigned nx;
      bit fire, hit, host_wp;
      bit [7:0] clr, setb;
      mb = int'(ind_mbox);
      m_rdata = model_read(int'(reg_addr));
      m_irq = |(m_stat & m_mask);
      m_halt = |m_stat[7:4];
      fire = ind_valid && mem_ready && !m_stat[4 + mb];
      nx = (m_wptr[mb] + STEP) & 16'hFFFF;
      if (nx == m_bound[mb]) nx = m_start[mb];
      hit = fire && (nx == m_tail[mb]);
      clr = 0; setb = 0;
      if (reg_wr_en && reg_addr == 4 * N) begin
        clr = reg_wdata[7:0];
        for (int i = 0; i < N; i++)
          if (m_tail[i] == m_wptr[i]) clr[4 + i] = 1'b0;
      end
      if (fire) begin
        setb[mb] = 1'b1;
        if (hit) setb[4 + mb] = 1'b1;
      end
      host_wp = reg_wr_en && reg_addr < 4 * N && (reg_addr % 4) == 2 && (reg_addr / 4) == mb;
      if (fire && !host_wp) m_wptr[mb] = nx;
      if (reg_wr_en && reg_addr < 4 * N) begin
        case (reg_addr % 4)
          0: m_start[reg_addr / 4] = reg_wdata;
          1: m_bound[reg_addr / 4] = reg_wdata;
          2: m_wptr[reg_addr / 4] = reg_wdata;
          default: m_tail[reg_addr / 4] = reg_wdata;
        endcase
      end
      if (reg_wr_en && reg_addr == 4 * N + 1) m_mask = reg_wdata[7:0];
      m_stat = (m_stat & ~clr) | setb;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #1;
    if (!rst && !finished) begin
      bit er;
      er = mem_ready && !m_stat[4 + int'(ind_mbox)];
      chk(ind_ready == er, "R7 ind_ready", ind_ready, er);
      chk(mem_wr_en == (ind_valid && er), "R2 mem_wr_en", mem_wr_en, ind_valid && er);
      if (mem_wr_en) begin
        chk(mem_addr == m_wptr[ind_mbox], "R3 mem_addr", mem_addr, m_wptr[ind_mbox]);
        chk(mem_wdata == ind_data, "R2 mem_wdata", mem_wdata, ind_data);
      end
      chk(irq == m_irq, "R8 irq", irq, m_irq);
      chk(halt == m_halt, "R6 halt", halt, m_halt);
      chk(reg_rdata == m_rdata, "R1 reg_rdata", reg_rdata, m_rdata);
    end
  end

  task automatic reg_wr(input int a, input int d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = RA_W'(a); reg_wdata = AW'(d);
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic post(input int mb, input int d);
    @(negedge clk);
    ind_valid = 1'b1; ind_mbox = 2'(mb); ind_data = DW'(d);
    @(negedge clk);
    ind_valid = 1'b0;
  endtask

  task automatic reg_rd(input int a, output int v);
    @(negedge clk);
    reg_addr = RA_W'(a);
    @(negedge clk);
    #1;
    v = int'(reg_rdata);
  endtask

  initial begin
    int v;
    repeat (4) @(negedge clk);
    #1;
    chk(irq == 0 && halt == 0, "R10 irq/halt in reset", {irq, halt}, 0);
    @(negedge clk); rst = 1'b0;
    reg_rd(16, v); chk(v == 0, "R10 status after reset", v, 0);
    reg_rd(17, v); chk(v == 0, "R10 enables after reset", v, 0);
    for (int m = 0; m < N; m++) begin
      reg_wr(4 * m + 0, 'h100 * (m + 1));
      reg_wr(4 * m + 1, 'h100 * (m + 1) + 'h40);
      reg_wr(4 * m + 2, 'h100 * (m + 1));
      reg_wr(4 * m + 3, 'h100 * (m + 1));
    end
    reg_rd(1 * 4 + 1, v); chk(v == 'h240, "R1 bound readback", v, 'h240);
    // masked post sets present bit only
    post(1, 'hA1);
    reg_rd(16, v); chk(v == 'h02, "R4 present bit", v, 'h02);
    chk(irq == 0, "R8 masked irq", irq, 0);
    reg_rd(1 * 4 + 2, v); chk(v == 'h210, "R3 advance", v, 'h210);
    reg_wr(17, 'hFF);
    repeat (2) @(negedge clk);
    #1 chk(irq == 1, "R8 enabled irq", irq, 1);
    reg_wr(16, 'h02);
    reg_rd(16, v); chk(v == 0, "R9 clear present", v, 0);
    // fill mailbox 0: four slots, wrap lands on tail
    for (int k = 0; k < 4; k++) post(0, 'hB0 + k);
    reg_rd(16, v); chk(v == 'h11, "R5 full bit", v, 'h11);
    reg_rd(2, v); chk(v == 'h100, "R3 wrap to first entry", v, 'h100);
    chk(halt == 1, "R6 halt asserted", halt, 1);
    @(negedge clk); ind_valid = 1'b1; ind_mbox = 0; ind_data = 'hDEAD;
    #1 chk(ind_ready == 0 && mem_wr_en == 0, "R7 full blocks post", {ind_ready, mem_wr_en}, 0);
    @(negedge clk); ind_mbox = 2;
    #1 chk(mem_wr_en == 1, "R7 other mailbox accepted", mem_wr_en, 1);
    @(negedge clk); ind_valid = 1'b0;
    // clear ignored while tail equals producer position
    reg_wr(16, 'h10);
    reg_rd(16, v); chk(v[4] == 1, "R9 full clear ignored", v, 'h10);
    reg_wr(3, 'h110);
    reg_wr(16, 'h10);
    reg_rd(16, v); chk(v[4] == 0, "R9 full released", v, 0);
    repeat (2) @(negedge clk);
    #1 chk(halt == 0, "R6 halt released", halt, 0);
    post(0, 'hC0);
    reg_rd(16, v); chk(v[4] == 1, "R5 refill to tail", v, 'h10);
    reg_wr(3, 'h120); reg_wr(16, 'h10);
    // memory port not ready
    @(negedge clk); ind_valid = 1'b1; ind_mbox = 3; mem_ready = 1'b0;
    #1 chk(ind_ready == 0 && mem_wr_en == 0, "R7 memory not ready", ind_ready, 0);
    @(negedge clk); ind_valid = 1'b0; mem_ready = 1'b1;
    // host producer write collides with post to mailbox 2
    @(negedge clk);
    ind_valid = 1'b1; ind_mbox = 2; ind_data = 'hE0;
    reg_wr_en = 1'b1; reg_addr = 2 * 4 + 2; reg_wdata = 'h320;
    @(negedge clk); ind_valid = 1'b0; reg_wr_en = 1'b0;
    reg_rd(2 * 4 + 2, v); chk(v == 'h320, "R11 host producer write wins", v, 'h320);
    // clear and set same cycle: set wins
    @(negedge clk);
    ind_valid = 1'b1; ind_mbox = 3; reg_wr_en = 1'b1; reg_addr = 16; reg_wdata = 'h08;
    @(negedge clk); ind_valid = 1'b0; reg_wr_en = 1'b0;
    reg_rd(16, v); chk(v[3] == 1, "R9 set beats clear", v, 'h08);
    reg_rd(31, v); chk(v == 0, "R1 unmapped reads zero", v, 0);
    // reset mid-run
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    #1 chk(irq == 0 && halt == 0 && reg_rdata == 0, "R10 reset clears", {irq, halt}, 0);
    @(negedge clk); rst = 1'b0;
    reg_rd(16, v); chk(v == 0, "R10 status cleared", v, 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule